// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Unit

This unit sits between a simple register bus and a serial shift engine. It buffers outgoing words in a transmit queue and incoming words in a receive queue, both eight entries deep and sixteen bits wide. The engine drains the transmit queue through a valid/take pair and fills the receive queue one word per `rx_push` pulse.

The unit raises one interrupt line from four sources. Two are live levels: the transmit queue is running low, and the receive queue has reached half full. Two are latched events: a receive timeout, and a receive overrun. A mask register selects which sources reach the line, and a clear register drops the latched events. Software reads the raw and the masked source views from separate addresses.

Top module: `spx_fifo_irq`

## Requirements
- R1: After reset both queues are empty, the mask is zero, `irq` is low, `tx_valid` is low, and a status read returns 1.
- R2: A bus write to address 0 appends a word to the transmit queue, which holds at most 8 words. A write while it holds 8 is dropped. `tx_valid` is high while the queue is non-empty, and `tx_data` shows the oldest word. `tx_take` removes that word.
- R3: A bus read of address 0 returns the oldest received word and removes it. A read while the receive queue is empty returns 0. `bus_rdata` is combinational and valid while `bus_rd` is high.
- R4: Register addresses are 0 data, 1 status, 2 raw sources, 3 mask, 4 masked sources and 5 clear. Status bit 0 is set when the transmit queue is not full. Status bit 1 is set when the receive queue is not empty.
- R5: Source bit 0 (transmit low) is set while the transmit queue holds 4 words or fewer.
- R6: Source bit 1 (receive level) is set while the receive queue holds 4 words or more.
- R7: Source bit 2 (timeout) latches when the receive queue stays non-empty for 32 `ser_tick` pulses without a data read. Any data read that removes a word restarts the count, and an empty queue holds the count at zero.
- R8: Source bit 3 (overrun) latches when `rx_push` arrives while the receive queue holds 8 words. That word is discarded.
- R9: A write to address 5 clears each latched source (bits 2 and 3) whose bit is set in the written value. A new event in the same cycle wins over the clear. Address 5 reads as 0.
- R10: The mask is the 4-bit value written to address 3, with one bit per source in the same positions, and it reads back from address 3. Address 4 returns the raw sources ANDed with the mask. `irq` is the OR of those bits, so a zero mask keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading |
| tx_valid | output | 1 | Transmit queue has a word |
| tx_data | output | 16 | Oldest transmit word |
| tx_take | input | 1 | Engine consumes the oldest transmit word |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | 16 | Received word |
| ser_tick | input | 1 | One pulse per serial clock period |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench fills each queue past capacity. A design that wrapped its count or accepted the ninth word would then overwrite the oldest entry, and the order of words would come out wrong. It runs the timeout to exactly 31 and then 32 ticks: an off-by-one counter would latch one tick early or late, and a timer that new arrivals restart would never latch under steady traffic. It also reads an empty receive queue and writes the clear register with only some bits set. A design that returned stale data, or that cleared every latched bit or none, shows a mismatch against the bench's reference model in the raw source view.

// File: rtl/spx_pkg.sv
package spx_pkg;
    typedef enum logic [2:0] {
        REG_DATA = 3'd0,
        REG_STAT = 3'd1,
        REG_RAW  = 3'd2,
        REG_MASK = 3'd3,
        REG_MIS  = 3'd4,
        REG_CLR  = 3'd5
    } reg_sel_e;

    localparam int SRC_TX = 0;
    localparam int SRC_RX = 1;
    localparam int SRC_TO = 2;
    localparam int SRC_OV = 3;
    localparam int NSRC   = 4;
endpackage

// File: rtl/spx_fifo.sv
module spx_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [WIDTH-1:0]              wdata,
    input  logic                          pop,
    output logic [WIDTH-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     take_in, give_out;

    always_comb begin
        st_d     = st_q;
        take_in  = push && (st_q.cnt != FULL);
        give_out = pop && (st_q.cnt != '0);
        if (take_in) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (give_out) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({take_in, give_out})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/spx_rx_timer.sv
module spx_rx_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic empty,
    output logic hit
);
    localparam int CW = $clog2(LIMIT+1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT-1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (restart || empty) begin
            st_d.cnt = '0;
        end else if (tick && st_q.cnt != TOP) begin
            st_d.cnt = st_q.cnt + 1'b1;
            hit      = (st_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spx_fifo_irq.sv
module spx_fifo_irq
    import spx_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int DEPTH    = 8,
    parameter int TO_LIMIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             tx_valid,
    output logic [WIDTH-1:0] tx_data,
    input  logic             tx_take,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_word,
    input  logic             ser_tick,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL   = CW'(DEPTH);
    localparam logic [CW-1:0] HALF   = CW'(DEPTH/2);

    typedef struct packed {
        logic            to;
        logic            ov;
        logic [NSRC-1:0] mask;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    logic [CW-1:0]    tx_count, rx_count;
    logic [WIDTH-1:0] rx_head;
    logic             rx_empty, rx_full, rx_pop, tx_push, to_hit, wr_clr;
    logic [NSRC-1:0]  raw, mis;

    assign rx_empty = (rx_count == '0);
    assign rx_full  = (rx_count == FULL);
    assign rx_pop   = bus_rd && (bus_addr == REG_DATA) && !rx_empty;
    assign tx_push  = bus_wr && (bus_addr == REG_DATA);
    assign wr_clr   = bus_wr && (bus_addr == REG_CLR);

    spx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
        .pop(tx_take), .rdata(tx_data), .count(tx_count)
    );

    spx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .count(rx_count)
    );

    spx_rx_timer #(.LIMIT(TO_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(ser_tick), .restart(rx_pop),
        .empty(rx_empty), .hit(to_hit)
    );

    always_comb begin
        raw         = '0;
        raw[SRC_TX] = (tx_count <= HALF);
        raw[SRC_RX] = (rx_count >= HALF);
        raw[SRC_TO] = st_q.to;
        raw[SRC_OV] = st_q.ov;
        mis         = raw & st_q.mask;
    end

    always_comb begin
        st_d    = st_q;
        st_d.to = (st_q.to & ~(wr_clr & bus_wdata[SRC_TO])) | to_hit;
        st_d.ov = (st_q.ov & ~(wr_clr & bus_wdata[SRC_OV])) | (rx_push & rx_full);
        if (bus_wr && bus_addr == REG_MASK) st_d.mask = bus_wdata[NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                REG_DATA: bus_rdata = rx_empty ? '0 : rx_head;
                REG_STAT: bus_rdata = WIDTH'({!rx_empty, tx_count != FULL});
                REG_RAW:  bus_rdata = WIDTH'(raw);
                REG_MASK: bus_rdata = WIDTH'(st_q.mask);
                REG_MIS:  bus_rdata = WIDTH'(mis);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign tx_valid = (tx_count != '0);
    assign irq      = |mis;
endmodule

// File: rtl/spx_fifo_irq_chk.sv
module spx_fifo_irq_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_rd,
    input logic [2:0]                 bus_addr,
    input logic [WIDTH-1:0]           bus_rdata,
    input logic                       rx_push,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [3:0]                 mask,
    input logic                       ovr
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    a_r8_overrun_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_cnt == FULL) |=> ovr);

    a_r8_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_cnt == FULL && !(bus_rd && bus_addr == 3'd0)) |=> rx_cnt == FULL);

    a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= FULL);

    a_r10_mask_silence: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'd0) |-> !irq);

    a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && rx_cnt == '0) |-> bus_rdata == '0);

    a_r4_status_rne: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd1) |-> bus_rdata[1] == (rx_cnt != '0));
endmodule

bind spx_fifo_irq spx_fifo_irq_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .rx_push(rx_push), .irq(irq),
    .rx_cnt(rx_count), .tx_cnt(tx_count), .mask(st_q.mask), .ovr(st_q.ov)
);

// File: tb/sim_spx_fifo_irq.sv
`timescale 1ns/1ps
module sim_spx_fifo_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_take = 1'b0, rx_push = 1'b0, ser_tick = 1'b0;
    logic [15:0] rx_word = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_txq[$];
    logic [15:0] m_rxq[$];
    logic [3:0]  m_mask = '0;
    bit          m_to = 0, m_ov = 0;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    spx_fifo_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .rx_push(rx_push), .rx_word(rx_word), .ser_tick(ser_tick), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_raw();
        return {m_ov, m_to, m_rxq.size() >= 4, m_txq.size() <= 4};
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return (m_rxq.size() == 0) ? 16'h0 : m_rxq[0];
            3'd1: return {14'h0, m_rxq.size() != 0, m_txq.size() < 8};
            3'd2: return {12'h0, m_raw()};
            3'd3: return {12'h0, m_mask};
            3'd4: return {12'h0, m_raw() & m_mask};
            default: return 16'h0;
        endcase
    endfunction

    task automatic cyc(input bit wr, input bit rd, input logic [2:0] a, input logic [15:0] wd,
                       input bit take, input bit push, input logic [15:0] word, input bit tick);
        int  txn, rxn;
        bit  rdpop, hit;
        logic [15:0] e;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        tx_take = take; rx_push = push; rx_word = word; ser_tick = tick;
        #1;
        if (rd) begin
            e = m_read(a);
            case (a)
                3'd0: chk("R3 data read", bus_rdata, e);
                3'd1: chk("R4 status", bus_rdata, e);
                3'd2: begin
                    chk("R5 raw tx-low", bus_rdata[0], e[0]);
                    chk("R6 raw rx-level", bus_rdata[1], e[1]);
                    chk("R7 raw timeout", bus_rdata[2], e[2]);
                    chk("R8 raw overrun", bus_rdata[3], e[3]);
                end
                3'd5: chk("R9 clear reads zero", bus_rdata, e);
                default: chk("R10 mask/masked read", bus_rdata, e);
            endcase
        end
        chk("R2 tx_valid", tx_valid, m_txq.size() != 0);
        if (m_txq.size() != 0) chk("R2 tx_data oldest", tx_data, m_txq[0]);
        @(posedge clk);
        txn = m_txq.size(); rxn = m_rxq.size();
        rdpop = rd && a == 3'd0 && rxn > 0;
        if (take && txn > 0) void'(m_txq.pop_front());
        if (wr && a == 3'd0 && txn < 8) m_txq.push_back(wd);
        if (rdpop) void'(m_rxq.pop_front());
        hit = tick && m_cnt == 31 && !rdpop && rxn != 0;
        if (rdpop || rxn == 0) m_cnt = 0;
        else if (tick && m_cnt < 32) m_cnt++;
        m_to = (m_to && !(wr && a == 3'd5 && wd[2])) || hit;
        m_ov = (m_ov && !(wr && a == 3'd5 && wd[3])) || (push && rxn == 8);
        if (push && rxn < 8) m_rxq.push_back(word);
        if (wr && a == 3'd3) m_mask = wd[3:0];
        #1;
        chk("R10 irq", irq, |(m_raw() & m_mask));
    endtask

    task automatic idle(); cyc(0,0,0,0,0,0,0,0); endtask
    task automatic rd_reg(input logic [2:0] a); cyc(0,1,a,0,0,0,0,0); endtask
    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d); cyc(1,0,a,d,0,0,0,0); endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", irq, 0);
        chk("R1 tx_valid after reset", tx_valid, 0);
        bus_rd = 1; bus_addr = 3'd1; #1;
        chk("R1 status after reset", bus_rdata, 16'h1);
        bus_addr = 3'd3; #1;
        chk("R1 mask after reset", bus_rdata, 16'h0);
        bus_rd = 0;

        // R2: nine writes, ninth dropped, then drain in order
        for (int i = 0; i < 9; i++) wr_reg(3'd0, 16'hA000 + 16'(i));
        rd_reg(3'd1); rd_reg(3'd2);
        for (int i = 0; i < 9; i++) cyc(0,0,0,0,1,0,0,0);
        rd_reg(3'd2);

        // R8/R3: overfill receive queue, drain, read empty
        for (int i = 0; i < 9; i++) cyc(0,0,0,0,0,1,16'h5100 + 16'(i),0);
        rd_reg(3'd2);
        for (int i = 0; i < 9; i++) rd_reg(3'd0);
        wr_reg(3'd5, 16'h0004);   // R9: timeout bit only, overrun stays
        rd_reg(3'd2);
        wr_reg(3'd5, 16'h0008);
        rd_reg(3'd2);

        // R7: timeout boundary, irq enabled for timeout only
        wr_reg(3'd3, 16'h0004);
        cyc(0,0,0,0,0,1,16'h7777,0);
        for (int i = 0; i < 31; i++) cyc(0,0,0,0,0,0,0,1);
        rd_reg(3'd2);
        cyc(0,0,0,0,0,0,0,1);
        rd_reg(3'd2); rd_reg(3'd4);
        rd_reg(3'd0);
        wr_reg(3'd5, 16'h000C);
        rd_reg(3'd2);
        wr_reg(3'd3, 16'h0000);
        idle();

        // random traffic in phases
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                int r;
                bit wr, rd, take, push, tick;
                logic [2:0] a;
                logic [15:0] d;
                r = $urandom_range(0, 9);
                wr = 0; rd = 0; a = 3'd0; d = 16'($urandom);
                case (r)
                    0, 1, 2: wr = 1;
                    3, 4:    rd = (ph != 1);
                    5, 6:    begin rd = 1; a = 3'($urandom_range(0, 5)); end
                    7:       begin wr = 1; a = 3'd3; end
                    8:       begin wr = 1; a = 3'd5; end
                    default: ;
                endcase
                take = ($urandom_range(0, 3) < ((ph == 0) ? 1 : 2));
                push = ($urandom_range(0, 3) < ((ph == 2) ? 1 : 2));
                tick = ($urandom_range(0, 1) == 1) || ph == 3;
                if (ph == 3 && r < 5) begin rd = 0; wr = 0; end
                cyc(wr, rd, a, d, take, push, 16'($urandom), tick);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule